// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. It shifts the segment left by four bits and adds the offset. It holds four segment registers: code, data, stack and extra. Software writes them through a simple write port. Each access picks one of the four registers with a 2-bit select. Instruction fetches pair the code segment with an internal 16-bit instruction pointer. Data, stack and extra accesses pair their segment with the offset on the data input.

The instruction pointer steps by one on a fetch-step strobe. A branch-load strobe replaces it with a supplied value. Stepping never carries into the code segment: when the pointer passes FFFF it wraps to 0000 and stays in the same 64K window. Software reaches code outside that window only by loading a new code segment. The address and its valid flag come out of a register one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, addr_valid is 0, phys_addr is 00000, and all four segment registers and the instruction pointer hold 0000.
- R2: A request in one cycle gives, in the next cycle, addr_valid = 1 and phys_addr = (segment << 4) + offset.
- R3: A carry out of bit 19 of the sum is dropped, so the address wraps modulo 2^20. For example, segment FFFF with offset 0010 gives 00000.
- R4: acc_sel and seg_wr_sel use the same encoding: 0 = code, 1 = data, 2 = stack, 3 = extra. Selects 1 to 3 use data_off as the offset.
- R5: A request with acc_sel = 0 uses the code segment and the current instruction pointer as the offset, and ignores data_off.
- R6: ip_step advances the instruction pointer by one. From FFFF it wraps to 0000 and leaves the code segment unchanged. With code segment C000, a fetch at pointer FFFF gives CFFFF, and the next fetch gives C0000.
- R7: ip_load sets the instruction pointer to ip_target. When both strobes are high in the same cycle, ip_load wins.
- R8: A segment write takes effect at the clock edge. A request in the same cycle as the write still uses the old value.
- R9: In a cycle with no request, addr_valid is 0 in the next cycle and phys_addr keeps its last value.
- R10: Without ip_step or ip_load, the instruction pointer keeps its value. A fetch that is made without ip_step does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Write strobe for a segment register |
| seg_wr_sel | input | 2 | Segment register to write (encoding as in R4) |
| seg_wr_data | input | 16 | New segment value |
| acc_req | input | 1 | Address request |
| acc_sel | input | 2 | Segment used by the request |
| data_off | input | 16 | Offset for data, stack and extra requests |
| ip_step | input | 1 | Advance the instruction pointer by one |
| ip_load | input | 1 | Load the instruction pointer from ip_target |
| ip_target | input | 16 | Branch target for ip_load |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | phys_addr is from the previous cycle's request |

## Verification
Every address result is due exactly one clock edge after its request cycle. Segment writes and pointer strobes become visible at the edge that ends the cycle in which they are driven. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the next falling edge, which is the first cycle in which the registered result can appear. For the same-cycle cases (a write together with a request, and a step together with a fetch), the bench checks the old-value result at that sample. It then makes a second request to see the new value one cycle later.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NUM_SEGS = 4;
    localparam int SEG_IDX_W = $clog2(NUM_SEGS);

    typedef enum logic [SEG_IDX_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0]     wr_val,
    input  logic [SEG_IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0]     rd_val
);
    logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
    logic [NUM_SEGS-1:0][SEG_W-1:0] seg_d;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        always_comb begin
            seg_d[g] = seg_q[g];
            if (wr_en && (wr_idx == SEG_IDX_W'(g))) begin
                seg_d[g] = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else begin
                seg_q[g] <= seg_d[g];
            end
        end
    end

    assign rd_val = seg_q[rd_idx];

    // R8: a write lands at the edge
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_q[$past(wr_idx)] == $past(wr_val));

    // R8: no write means no change
    a_r8_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(seg_q));
endmodule

// File: rtl/ip_counter.sv
module ip_counter #(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [OFF_W-1:0] target,
    output logic [OFF_W-1:0] ip
);
    typedef struct packed {
        logic [OFF_W-1:0] ptr;
    } ip_state_t;

    ip_state_t st_q;
    ip_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ptr = target;
        end else if (step) begin
            st_d.ptr = st_q.ptr + OFF_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ip = st_q.ptr;

    // R6: wrap from all-ones to zero
    a_r6_ip_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (&st_q.ptr)) |=> (st_q.ptr == '0));

    // R7: load takes priority
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.ptr == $past(target)));

    // R10: hold without strobes
    a_r10_ip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(st_q.ptr));
endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] seg_ext;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        seg_ext = {seg, {SHIFT{1'b0}}};
        off_ext = ADDR_W'(off);
        addr    = seg_ext + off_ext;
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_wr_en,
    input  logic [SEG_IDX_W-1:0] seg_wr_sel,
    input  logic [SEG_W-1:0]     seg_wr_data,
    input  logic                 acc_req,
    input  logic [SEG_IDX_W-1:0] acc_sel,
    input  logic [OFF_W-1:0]     data_off,
    input  logic                 ip_step,
    input  logic                 ip_load,
    input  logic [OFF_W-1:0]     ip_target,
    output logic [ADDR_W-1:0]    phys_addr,
    output logic                 addr_valid
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } out_state_t;

    logic [SEG_W-1:0]  seg_val;
    logic [OFF_W-1:0]  ip_cur;
    logic [OFF_W-1:0]  off_sel;
    logic [ADDR_W-1:0] addr_sum;
    out_state_t        out_q;
    out_state_t        out_d;

    seg_bank #(.SEG_W(SEG_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (seg_wr_en),
        .wr_idx (seg_wr_sel),
        .wr_val (seg_wr_data),
        .rd_idx (acc_sel),
        .rd_val (seg_val)
    );

    ip_counter #(.OFF_W(OFF_W)) u_ip (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (ip_step),
        .load   (ip_load),
        .target (ip_target),
        .ip     (ip_cur)
    );

    always_comb begin
        off_sel = (acc_sel == SEG_CODE) ? ip_cur : data_off;
    end

    phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg  (seg_val),
        .off  (off_sel),
        .addr (addr_sum)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = acc_req;
        if (acc_req) begin
            out_d.addr = addr_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign phys_addr  = out_q.addr;
    assign addr_valid = out_q.valid;

    // R2: request gives valid next cycle
    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> addr_valid);

    // R9: idle cycle clears valid and holds the address
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (!addr_valid && $stable(phys_addr)));

    // R5: fetch low bits come straight from the pointer
    a_r5_fetch_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_sel == SEG_CODE) |=>
            (phys_addr[SHIFT-1:0] == $past(ip_cur[SHIFT-1:0])));
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = 2'd0;
    logic [15:0] seg_wr_data = 16'h0;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_sel = 2'd0;
    logic [15:0] data_off = 16'h0;
    logic        ip_step = 1'b0;
    logic        ip_load = 1'b0;
    logic [15:0] ip_target = 16'h0;
    logic [19:0] phys_addr;
    logic        addr_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .acc_req(acc_req), .acc_sel(acc_sel), .data_off(data_off),
        .ip_step(ip_step), .ip_load(ip_load), .ip_target(ip_target),
        .phys_addr(phys_addr), .addr_valid(addr_valid)
    );

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_seg(input logic [1:0] idx, input logic [15:0] val);
        seg_wr_en = 1'b1; seg_wr_sel = idx; seg_wr_data = val;
        tick();
        seg_wr_en = 1'b0;
    endtask

    task automatic access(input string req, input logic [1:0] sel,
                          input logic [15:0] off, input logic [19:0] exp);
        acc_req = 1'b1; acc_sel = sel; data_off = off;
        tick();
        acc_req = 1'b0;
        chk(req, phys_addr, exp);
        chk(req, 20'(addr_valid), 20'h1);
    endtask

    task automatic t_reset();
        chk("R1 valid", 20'(addr_valid), 20'h0);
        chk("R1 addr", phys_addr, 20'h0);
        access("R1 fetch", 2'd0, 16'h7777, 20'h00000);
        access("R1 data", 2'd1, 16'h0000, 20'h00000);
        access("R1 extra", 2'd3, 16'h0000, 20'h00000);
    endtask

    task automatic t_select();
        wr_seg(2'd1, 16'hABCD);
        wr_seg(2'd2, 16'h1234);
        wr_seg(2'd3, 16'h2000);
        access("R2 data", 2'd1, 16'h0123, 20'hABDF3);
        access("R4 stack", 2'd2, 16'h5678, 20'h179B8);
        access("R4 extra", 2'd3, 16'h0001, 20'h20001);
    endtask

    task automatic t_carry();
        wr_seg(2'd3, 16'hFFFF);
        access("R3 wrap", 2'd3, 16'h0010, 20'h00000);
        access("R3 top", 2'd3, 16'h000F, 20'hFFFFF);
    endtask

    task automatic t_fetch_wrap();
        wr_seg(2'd0, 16'hC000);
        ip_load = 1'b1; ip_target = 16'hFFFF;
        tick();
        ip_load = 1'b0;
        acc_req = 1'b1; acc_sel = 2'd0; data_off = 16'h1111; ip_step = 1'b1;
        tick();
        chk("R6 fetch at FFFF", phys_addr, 20'hCFFFF);
        tick();
        chk("R6 fetch after wrap", phys_addr, 20'hC0000);
        tick();
        acc_req = 1'b0; ip_step = 1'b0;
        chk("R6 next step", phys_addr, 20'hC0001);
        access("R5 fetch ignores data_off", 2'd0, 16'h9999, 20'hC0002);
    endtask

    task automatic t_load();
        ip_load = 1'b1; ip_step = 1'b1; ip_target = 16'h1234;
        tick();
        ip_load = 1'b0; ip_step = 1'b0;
        access("R7 load over step", 2'd0, 16'h0000, 20'hC1234);
        access("R10 hold", 2'd0, 16'h0000, 20'hC1234);
    endtask

    task automatic t_same_cycle_write();
        wr_seg(2'd1, 16'h1000);
        seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h2000;
        acc_req = 1'b1; acc_sel = 2'd1; data_off = 16'h0005;
        tick();
        seg_wr_en = 1'b0; acc_req = 1'b0;
        chk("R8 old value", phys_addr, 20'h10005);
        access("R8 new value", 2'd1, 16'h0005, 20'h20005);
    endtask

    task automatic t_idle();
        access("R9 prime", 2'd2, 16'h0000, 20'h12340);
        data_off = 16'hFFFF; acc_sel = 2'd1;
        tick();
        chk("R9 valid low", 20'(addr_valid), 20'h0);
        chk("R9 addr held", phys_addr, 20'h12340);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_carry();
        t_fetch_wrap();
        t_load();
        t_same_cycle_write();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%05h expected=%05h", 20'h0, 20'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule